// File: doc/BRIEF.md
# Pipeline Exception Flush Controller

This block is the control side of precise exceptions in a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). The execute stage reports an undefined opcode or an arithmetic overflow for the instruction it holds. The controller decides in that same cycle that the exception is taken, and it cancels the faulting instruction and everything younger. The fetch/decode register is cleared to a NOP. The control bits entering decode/execute are zeroed. The control bits entering execute/memory are also zeroed, so the faulting instruction never writes the register file or memory. Instructions already in memory and writeback are untouched and finish normally.

In the same cycle, the block steers the program counter multiplexer to a fixed handler vector. It also writes a 5-bit cause code and the faulting instruction's own address into two state registers. The decode/execute bubble is shared with the hazard unit's load-use stall, so one signal zeroes that register for either reason. The block also owns the fetch PC register: sequential increment, taken-branch redirect, stall hold and the vector override. A clear input resets the cause code after a handler returns.

Top module: `pipe_exc_ctrl`

## Requirements
- R1: While reset is asserted, on the next clock edge fetch_pc becomes RESET_PC (0x00000000), and cause_q and epc_q become zero.
- R2: An exception is taken only when ex_valid is 1 and at least one of ex_undef_op or ex_arith_ovf is 1. Exception flags with ex_valid at 0 change no output and no register.
- R3: In the cycle an exception is taken, ifid_flush, idex_bubble and exmem_kill are all 1 together.
- R4: idex_bubble is the OR of hz_load_use_stall and a taken exception. A stall with no exception holds fetch_pc and the fetch/decode register (pc_write_en = ifid_write_en = 0) and asserts neither ifid_flush nor exmem_kill.
- R5: In the taking cycle, pc_from_vector is 1. On the next cycle fetch_pc is 0x80000180, whatever the stall and branch inputs were.
- R6: The cause code written is 10 for an undefined opcode and 12 for an arithmetic overflow. When both flags are raised together, the undefined opcode wins (code 10).
- R7: epc_q, after a taken exception, equals ex_pc_plus4 minus 4 as presented in the taking cycle.
- R8: cause_we and epc_we are 1 only in the taking cycle. At all other times epc_q keeps its value, and cause_q keeps its value unless R9 applies.
- R9: exc_clear sets cause_q to 0 on the next edge and leaves epc_q unchanged. A taken exception in the same cycle overrides the clear.
- R10: With no exception and no stall, fetch_pc advances by 4 each cycle. If br_taken is 1, it loads br_target instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_undef_op | input | 1 | Execute-stage instruction has an undefined opcode |
| ex_arith_ovf | input | 1 | Execute-stage instruction overflowed |
| ex_pc_plus4 | input | XLEN | Execute-stage instruction address plus 4 |
| hz_load_use_stall | input | 1 | Load-use stall from the hazard unit |
| br_taken | input | 1 | Taken-branch redirect request |
| br_target | input | XLEN | Branch destination |
| exc_clear | input | 1 | Clear the cause register |
| fetch_pc | output | XLEN | Current fetch address |
| pc_from_vector | output | 1 | PC multiplexer selects the handler vector |
| pc_write_en | output | 1 | PC register loads this cycle |
| ifid_write_en | output | 1 | Fetch/decode register loads this cycle |
| ifid_flush | output | 1 | Clear fetch/decode register to NOP |
| idex_bubble | output | 1 | Zero control bits into decode/execute |
| exmem_kill | output | 1 | Zero control bits into execute/memory |
| cause_we | output | 1 | Cause register write strobe |
| epc_we | output | 1 | Exception-PC register write strobe |
| cause_q | output | 5 | Stored cause code |
| epc_q | output | XLEN | Stored faulting-instruction address |

## Verification
The flush path is driven with quiet cycles, a lone branch, a lone stall, flags without ex_valid, each exception kind on its own, both kinds together, and exceptions that collide with a stall and a branch. Together these separate a real exception from stray flags, the stall-only bubble from a full flush, and the vector override from the normal PC choices. The directed cases cover the cause priority, the minus-4 arithmetic on the saved address, holding state between exceptions, and the clear racing against a new exception. A bench model of the PC, built from the requirements, checks that fetch lands on the vector exactly one cycle after detection.

// File: rtl/exc_pkg.sv
// Package: shared constants and the cause-code type for the exception
// flush controller. Assumes a 4-byte fixed instruction width.
package exc_pkg;
    localparam int CAUSE_W     = 5;
    localparam int INSTR_BYTES = 4;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE  = 5'd0,
        CAUSE_UNDEF = 5'd10,
        CAUSE_OVF   = 5'd12
    } cause_t;
endpackage

// File: rtl/exc_detect.sv
// Module: exc_detect
// Decides whether the execute-stage instruction raises an exception and
// encodes its cause. Assumes the flags are meaningful only with ex_valid.
// The undefined opcode is found earlier in the instruction's life, so it
// outranks an overflow on the same instruction.
module exc_detect
    import exc_pkg::*;
(
    input  logic   ex_valid,
    input  logic   ex_undef_op,
    input  logic   ex_arith_ovf,
    output logic   exc_take,
    output cause_t exc_cause
);
    // Gate the flags with the valid bit and pick the older cause
    always_comb begin
        exc_take  = ex_valid & (ex_undef_op | ex_arith_ovf);
        exc_cause = CAUSE_NONE;
        if (ex_valid) begin
            if (ex_undef_op)       exc_cause = CAUSE_UNDEF;
            else if (ex_arith_ovf) exc_cause = CAUSE_OVF;
        end
    end
endmodule

// File: rtl/flush_ctrl.sv
// Module: flush_ctrl
// Produces the per-stage flush and write-enable controls. Assumes
// the pipeline registers honour flush over write enable. A taken
// exception overrides the load-use stall, so the PC and fetch/decode
// register keep loading while the stall's bubble is still inserted.
module flush_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic exc_take,
    input  logic hz_load_use_stall,
    output logic ifid_flush,
    output logic idex_bubble,
    output logic exmem_kill,
    output logic pc_write_en,
    output logic ifid_write_en
);
    // Combine the exception and the hazard stall into stage controls
    always_comb begin
        ifid_flush    = exc_take;
        idex_bubble   = exc_take | hz_load_use_stall;
        exmem_kill    = exc_take;
        pc_write_en   = exc_take | ~hz_load_use_stall;
        ifid_write_en = exc_take | ~hz_load_use_stall;
    end

    // R3: a kill of the faulting instruction comes with all younger flushes
    assert_flush_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        exmem_kill |-> (ifid_flush && idex_bubble && pc_write_en));

    // R4: a stall by itself never removes an instruction
    assert_stall_alone_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hz_load_use_stall && !exc_take) |-> (!ifid_flush && !exmem_kill && !pc_write_en));
endmodule

// File: rtl/pc_sel_unit.sv
// Module: pc_sel_unit
// Fetch PC register with its next-PC multiplexer. The priority is:
// handler vector, then stall hold, then branch target, then sequential.
// Assumes the write enable already contains the exception override.
module pc_sel_unit #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] VECTOR   = 32'h8000_0180,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exc_take,
    input  logic            pc_write_en,
    input  logic            br_taken,
    input  logic [XLEN-1:0] br_target,
    output logic            pc_from_vector,
    output logic [XLEN-1:0] fetch_pc
);
    localparam logic [XLEN-1:0] STEP = XLEN'(exc_pkg::INSTR_BYTES);

    logic [XLEN-1:0] next_pc;

    // Select the next fetch address
    always_comb begin
        pc_from_vector = exc_take;
        if (exc_take)      next_pc = VECTOR;
        else if (br_taken) next_pc = br_target;
        else               next_pc = fetch_pc + STEP;
    end

    // Hold or load the fetch PC
    always_ff @(posedge clk) begin
        if (!rst_n)           fetch_pc <= RESET_PC;
        else if (pc_write_en) fetch_pc <= next_pc;
    end

    // R5: fetch resumes at the vector one cycle after detection
    assert_vector_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_from_vector |=> (fetch_pc == VECTOR));

    // R4: a disabled PC write leaves the fetch address alone
    assert_pc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_write_en |=> $stable(fetch_pc));
endmodule

// File: rtl/exc_regs.sv
// Module: exc_regs
// Cause and exception-PC state registers. Both are written only in the
// cycle an exception is taken. The saved PC is the faulting instruction's
// own address, recovered from its PC+4. A clear zeroes only the cause.
module exc_regs
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exc_take,
    input  cause_t             exc_cause,
    input  logic [XLEN-1:0]    ex_pc_plus4,
    input  logic               exc_clear,
    output logic               cause_we,
    output logic               epc_we,
    output logic [CAUSE_W-1:0] cause_q,
    output logic [XLEN-1:0]    epc_q
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

    logic [XLEN-1:0] epc_d;

    // Form the write strobes and the faulting address
    always_comb begin
        cause_we = exc_take;
        epc_we   = exc_take;
        epc_d    = ex_pc_plus4 - STEP;
    end

    // Cause register: exception write beats clear
    always_ff @(posedge clk) begin
        if (!rst_n)         cause_q <= CAUSE_NONE;
        else if (cause_we)  cause_q <= exc_cause;
        else if (exc_clear) cause_q <= CAUSE_NONE;
    end

    // Exception-PC register
    always_ff @(posedge clk) begin
        if (!rst_n)      epc_q <= '0;
        else if (epc_we) epc_q <= epc_d;
    end

    // R6: a written cause is always one of the two defined codes
    assert_cause_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cause_we |=> (cause_q == CAUSE_UNDEF || cause_q == CAUSE_OVF));

    // R7: saved PC plus one instruction equals the PC+4 seen at capture
    assert_epc_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        epc_we |=> (epc_q + STEP == $past(ex_pc_plus4)));

    // R8: the exception PC holds whenever it is not written
    assert_epc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !epc_we |=> $stable(epc_q));

    // R9: a clear without an exception empties the cause
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_clear && !cause_we) |=> (cause_q == CAUSE_NONE));
endmodule

// File: rtl/pipe_exc_ctrl.sv
// Module: pipe_exc_ctrl (top)
// Exception flush controller for a five-stage in-order pipeline. It
// detects execute-stage exceptions, flushes the younger stages and the
// faulting instruction, redirects fetch to the handler vector and captures
// the cause and faulting PC. Assumes the memory and writeback stages are
// never touched, so older instructions drain on their own.
module pipe_exc_ctrl
    import exc_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] VECTOR   = 32'h8000_0180,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ex_valid,
    input  logic               ex_undef_op,
    input  logic               ex_arith_ovf,
    input  logic [XLEN-1:0]    ex_pc_plus4,
    input  logic               hz_load_use_stall,
    input  logic               br_taken,
    input  logic [XLEN-1:0]    br_target,
    input  logic               exc_clear,
    output logic [XLEN-1:0]    fetch_pc,
    output logic               pc_from_vector,
    output logic               pc_write_en,
    output logic               ifid_write_en,
    output logic               ifid_flush,
    output logic               idex_bubble,
    output logic               exmem_kill,
    output logic               cause_we,
    output logic               epc_we,
    output logic [CAUSE_W-1:0] cause_q,
    output logic [XLEN-1:0]    epc_q
);
    logic   exc_take;
    cause_t exc_cause;

    exc_detect u_detect (
        .ex_valid     (ex_valid),
        .ex_undef_op  (ex_undef_op),
        .ex_arith_ovf (ex_arith_ovf),
        .exc_take     (exc_take),
        .exc_cause    (exc_cause)
    );

    flush_ctrl u_flush (
        .clk               (clk),
        .rst_n             (rst_n),
        .exc_take          (exc_take),
        .hz_load_use_stall (hz_load_use_stall),
        .ifid_flush        (ifid_flush),
        .idex_bubble       (idex_bubble),
        .exmem_kill        (exmem_kill),
        .pc_write_en       (pc_write_en),
        .ifid_write_en     (ifid_write_en)
    );

    pc_sel_unit #(
        .XLEN     (XLEN),
        .VECTOR   (VECTOR),
        .RESET_PC (RESET_PC)
    ) u_pc (
        .clk            (clk),
        .rst_n          (rst_n),
        .exc_take       (exc_take),
        .pc_write_en    (pc_write_en),
        .br_taken       (br_taken),
        .br_target      (br_target),
        .pc_from_vector (pc_from_vector),
        .fetch_pc       (fetch_pc)
    );

    exc_regs #(
        .XLEN (XLEN)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .exc_take    (exc_take),
        .exc_cause   (exc_cause),
        .ex_pc_plus4 (ex_pc_plus4),
        .exc_clear   (exc_clear),
        .cause_we    (cause_we),
        .epc_we      (epc_we),
        .cause_q     (cause_q),
        .epc_q       (epc_q)
    );

    // R2: flags without a valid instruction are never taken
    assert_invalid_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_valid |-> (!exmem_kill && !cause_we && !pc_from_vector));
endmodule

// File: tb/pipe_exc_ctrl_test.sv
module pipe_exc_ctrl_test;
    localparam int          XLEN = 32;
    localparam logic [31:0] VEC  = 32'h8000_0180;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ex_valid = 0, ex_undef_op = 0, ex_arith_ovf = 0;
    logic [XLEN-1:0] ex_pc_plus4 = '0;
    logic            hz_load_use_stall = 0, br_taken = 0, exc_clear = 0;
    logic [XLEN-1:0] br_target = '0;
    logic [XLEN-1:0] fetch_pc, epc_q;
    logic            pc_from_vector, pc_write_en, ifid_write_en;
    logic            ifid_flush, idex_bubble, exmem_kill, cause_we, epc_we;
    logic [4:0]      cause_q;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_pc, exp_epc;
    logic [4:0]  exp_cause;

    always #5 clk = ~clk;

    pipe_exc_ctrl #(.XLEN(XLEN)) uut (
        .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_undef_op(ex_undef_op),
        .ex_arith_ovf(ex_arith_ovf), .ex_pc_plus4(ex_pc_plus4),
        .hz_load_use_stall(hz_load_use_stall), .br_taken(br_taken),
        .br_target(br_target), .exc_clear(exc_clear), .fetch_pc(fetch_pc),
        .pc_from_vector(pc_from_vector), .pc_write_en(pc_write_en),
        .ifid_write_en(ifid_write_en), .ifid_flush(ifid_flush),
        .idex_bubble(idex_bubble), .exmem_kill(exmem_kill), .cause_we(cause_we),
        .epc_we(epc_we), .cause_q(cause_q), .epc_q(epc_q)
    );

    // Vector bits: [13] valid [12] undef [11] ovf [10] stall [9] branch
    // [8] ifid_flush [7] idex_bubble [6] exmem_kill [5] vector [4:0] cause
    localparam logic [13:0] VECS [9] = '{
        14'b00000_0000_00000,   // idle: sequential fetch (R10)
        14'b00001_0000_00000,   // branch only (R10)
        14'b00010_0100_00000,   // load-use stall only (R4)
        14'b01100_0000_00000,   // flags without valid (R2)
        14'b10100_1111_01100,   // overflow (R3 R6)
        14'b11000_1111_01010,   // undefined opcode (R3 R6)
        14'b11111_1111_01010,   // both flags, stall, branch (R5 R6)
        14'b10110_1111_01100,   // overflow during stall (R4 R5)
        14'b10011_0100_00000    // valid, no exception, stall and branch (R4)
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic drive(input logic v, input logic u, input logic o, input logic s,
                         input logic b, input logic [31:0] pc4, input logic [31:0] tgt,
                         input logic clr);
        ex_valid = v; ex_undef_op = u; ex_arith_ovf = o; hz_load_use_stall = s;
        br_taken = b; ex_pc_plus4 = pc4; br_target = tgt; exc_clear = clr;
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(fetch_pc == 32'h0, "R1 fetch_pc", fetch_pc, 32'h0);
        check(cause_q == 5'd0, "R1 cause_q", 32'(cause_q), 0);
        check(epc_q == 32'h0, "R1 epc_q", epc_q, 0);
        rst_n = 1'b1;
        exp_pc = 32'h0; exp_cause = 5'd0; exp_epc = 32'h0;

        for (int i = 0; i < 9; i++) begin
            logic [13:0] v;
            logic [3:0]  got, want;
            logic [31:0] pc4, tgt;
            v   = VECS[i];
            pc4 = 32'h1000 + 32'(i) * 16;
            tgt = 32'h4000 + 32'(i) * 8;
            drive(v[13], v[12], v[11], v[10], v[9], pc4, tgt, 1'b0);
            #1;
            got  = {ifid_flush, idex_bubble, exmem_kill, pc_from_vector};
            want = v[8:5];
            check(got == want, "R3 R4 R2 flush controls", 32'(got), 32'(want));
            check(pc_write_en == (v[5] | ~v[10]) && ifid_write_en == (v[5] | ~v[10]),
                  "R4 write enables", {30'b0, pc_write_en, ifid_write_en},
                  {30'b0, v[5] | ~v[10], v[5] | ~v[10]});
            check(cause_we == v[5] && epc_we == v[5], "R8 write strobes",
                  {30'b0, cause_we, epc_we}, {30'b0, v[5], v[5]});
            if (v[5]) begin
                exp_pc = VEC; exp_cause = v[4:0]; exp_epc = pc4 - 32'd4;
            end else if (v[10]) begin
                exp_pc = exp_pc;
            end else if (v[9]) begin
                exp_pc = tgt;
            end else begin
                exp_pc = exp_pc + 32'd4;
            end
            @(negedge clk);
            check(fetch_pc == exp_pc, "R5 R10 fetch_pc", fetch_pc, exp_pc);
            check(cause_q == exp_cause, "R6 R8 cause_q", 32'(cause_q), 32'(exp_cause));
            check(epc_q == exp_epc, "R7 R8 epc_q", epc_q, exp_epc);
        end

        // R9: clear zeroes the cause and keeps the exception PC
        drive(0, 0, 0, 0, 0, 32'h0, 32'h0, 1'b1);
        @(negedge clk);
        check(cause_q == 5'd0, "R9 clear cause", 32'(cause_q), 0);
        check(epc_q == exp_epc, "R9 clear keeps epc", epc_q, exp_epc);

        // R9: exception in the same cycle overrides the clear
        drive(1, 0, 1, 0, 0, 32'h0000_2004, 32'h0, 1'b1);
        @(negedge clk);
        check(cause_q == 5'd12, "R9 exception beats clear", 32'(cause_q), 12);
        check(epc_q == 32'h0000_2000, "R7 epc minus 4", epc_q, 32'h0000_2000);

        // R8: idle cycles hold cause and epc; R2 invalid flags do not write
        drive(0, 1, 0, 0, 0, 32'h0000_9999, 32'h0, 1'b0);
        repeat (2) @(negedge clk);
        check(cause_q == 5'd12, "R2 R8 cause held", 32'(cause_q), 12);
        check(epc_q == 32'h0000_2000, "R2 R8 epc held", epc_q, 32'h0000_2000);

        // R4: a stall over several cycles keeps fetch_pc fixed
        drive(0, 0, 0, 0, 0, 32'h0, 32'h0, 1'b0);
        @(negedge clk);
        exp_pc = fetch_pc;
        drive(0, 0, 0, 1, 1, 32'h0, 32'h0000_7000, 1'b0);
        repeat (3) @(negedge clk);
        check(fetch_pc == exp_pc, "R4 stall hold", fetch_pc, exp_pc);

        // R5: vector overrides branch with no stall
        drive(1, 1, 0, 0, 1, 32'h0000_3008, 32'h0000_7000, 1'b0);
        @(negedge clk);
        check(fetch_pc == VEC, "R5 vector over branch", fetch_pc, VEC);
        check(cause_q == 5'd10, "R6 undefined code", 32'(cause_q), 10);

        // R1: re-entering reset restores the reset values
        drive(0, 0, 0, 0, 0, 32'h0, 32'h0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check(fetch_pc == 32'h0 && cause_q == 5'd0 && epc_q == 32'h0, "R1 second reset",
              fetch_pc, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule